// File: doc/BRIEF.md
# Sixteen-Bit Register-Pair Word Unit

This block performs 16-bit arithmetic and transfers between an 8-bit register pair and a 16-bit word held as two bytes in a byte-wide memory. The pair treats its lower register as bits 7:0 and its upper register as bits 15:8. On a start strobe the unit captures the operation, the pair value and a location, given as a page number and an in-page byte offset. It then reads the low byte of the memory word and, in the cycle that follows, the high byte. The high byte is taken from the next offset, and that offset wraps within the same page. Increment and decrement write each byte back in the same cycle in which the byte is read.

When the second access is complete the unit raises a one-cycle done pulse. With that pulse it presents the 16-bit result, a five-bit flag vector, per-flag write enables and a pair write enable, and it holds the result and the flags until the next done. The host applies these values to its own registers. Parameters set the address width and the page width, and a third parameter chooses between a chained two-byte adder and a single 17-bit adder. Both adders give the same results.

Top module: `word_pair_alu`

## Requirements
- R1: Operation code 5 (load word) returns the memory word on `result`, with the byte at the offset as bits 7:0 and the byte at the next offset as bits 15:8. It asserts `pair_we`, and only the N and Z enables are set.
- R2: Operation code 0 (add word) returns pair + word modulo 2^16 and enables all five flags. C is the carry out of bit 15 and V is signed 16-bit overflow. H is bit 4 of (pair[15:8] XOR word[15:8] XOR result[15:8]). `pair_we` is set.
- R3: Operation code 1 (subtract word) returns pair + (NOT word) + 1 modulo 2^16 and enables all five flags. C is 1 when no borrow occurs. V is signed overflow of pair − word. H is bit 4 of (pair[15:8] XOR NOT word[15:8] XOR result[15:8]). `pair_we` is set.
- R4: For every operation that enables N and Z, N equals result bit 15, and Z is 1 only when all 16 result bits are zero. The flag vector is ordered N,V,H,Z,C from bit 4 down to bit 0, and `flag_we` uses the same order.
- R5: Operation code 2 (compare word) returns pair − word. It enables only N, Z and C, with C = 1 when pair ≥ word as unsigned values. It writes neither the pair nor memory.
- R6: Operation codes 3 (increment word) and 4 (decrement word) write word + 1 or word − 1 back to memory. The low byte is written in the cycle after start and the high byte in the cycle after that, with the carry or borrow of the low byte passed into the high byte. The new word appears on `result`, only N and Z are enabled, and `pair_we` stays 0.
- R7: The low-byte access uses address {page, offset}. The high-byte access uses {page, (offset + 1) mod 2^PAGE_W}, so it never leaves the page.
- R8: The low-byte access (`mem_rd` high) occurs in the cycle after the start is accepted, and the high-byte access occurs in the next cycle. `done` is high for exactly the single cycle after the high-byte access. `result` and `flag_out` hold their values until the next done.
- R9: A start that arrives while `busy` is high is ignored. It triggers no extra access and no extra done pulse, and it does not change the result of the operation already in progress.
- R10: Operation codes 6 and 7 perform both reads but write no memory byte, set no flag enable and leave `pair_we` at 0. They still produce the done pulse.
- R11: While reset is asserted and after reset is released, `busy`, `done`, `mem_rd`, `mem_wr`, `pair_we`, `flag_we` and `result` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (accepted when not busy) |
| op | input | 3 | Operation code (0 add, 1 sub, 2 cmp, 3 inc, 4 dec, 5 load) |
| page | input | ADDR_W-PAGE_W | Page number of the memory word |
| offset | input | PAGE_W | In-page offset of the low byte |
| pair_in | input | 16 | Register pair, low register in bits 7:0 |
| busy | output | 1 | Operation in progress |
| mem_addr | output | ADDR_W | Byte address of the current access |
| mem_rd | output | 1 | Read strobe, data expected on mem_rdata in the same cycle |
| mem_wr | output | 1 | Write strobe for mem_wdata |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read from mem_addr |
| done | output | 1 | One-cycle completion pulse |
| result | output | 16 | New pair value, difference or new memory word |
| flag_out | output | 5 | Flags N,V,H,Z,C (bit 4 down to 0) |
| flag_we | output | 5 | Per-flag write enables, valid with done |
| pair_we | output | 1 | Pair write enable, valid with done |

## Verification
The low-byte access falls one edge after the start is sampled, the high-byte access one edge later, and the done pulse with its registered results in the cycle after the high-byte access. The bench drives its inputs on falling edges. It logs every memory access at rising edges, together with the cycle number, and reads the outputs on falling edges. It confirms that `done` is low after the first access, high after the second and low again one cycle later. It also checks that the two logged accesses fall in consecutive cycles right after the start edge. The result, flags, enables and memory contents are compared only in the done cycle and against arithmetic computed in the bench.

// File: rtl/pw_pkg.sv
package pw_pkg;

   typedef enum logic [2:0] {
      PW_ADDW = 3'd0,
      PW_SUBW = 3'd1,
      PW_CMPW = 3'd2,
      PW_INCW = 3'd3,
      PW_DECW = 3'd4,
      PW_LDW  = 3'd5,
      PW_RSV6 = 3'd6,
      PW_RSV7 = 3'd7
   } pw_op_e;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_LO   = 2'd1,
      SQ_HI   = 2'd2
   } pw_seq_e;

   // flag vector order: N V H Z C (bit 4 .. bit 0)
   typedef struct packed {
      logic n;
      logic v;
      logic h;
      logic z;
      logic c;
   } pw_flags_t;

   localparam int PW_FLAG_W = 5;

endpackage

// File: rtl/pw_word_core.sv
module pw_word_core
   import pw_pkg::*;
#(
   parameter bit SPLIT_ADD = 1'b1,
   parameter int WORD_W    = 16
) (
   input  pw_op_e               op,
   input  logic [WORD_W-1:0]    pair,
   input  logic [WORD_W-1:0]    mword,
   output logic [WORD_W-1:0]    res,
   output pw_flags_t            flg,
   output logic [PW_FLAG_W-1:0] flg_we,
   output logic                 pair_we,
   output logic                 mem_we
);
   localparam int HALF_W = WORD_W / 2;

   logic [WORD_W-1:0] xa;
   logic [WORD_W-1:0] yb;
   logic              cin;
   logic [WORD_W:0]   sum;

   // operand steering: every operation is one add with carry-in
   always_comb begin
      xa  = pair;
      yb  = '0;
      cin = 1'b0;
      unique case (op)
         PW_ADDW: begin
            xa = pair;
            yb = mword;
         end
         PW_SUBW, PW_CMPW: begin
            xa  = pair;
            yb  = ~mword;
            cin = 1'b1;
         end
         PW_INCW: begin
            xa  = mword;
            cin = 1'b1;
         end
         PW_DECW: begin
            xa = mword;
            yb = '1;
         end
         PW_LDW: begin
            xa = '0;
            yb = mword;
         end
         default: begin
            xa = pair;
         end
      endcase
   end

   generate
      if (SPLIT_ADD) begin : g_split
         logic [HALF_W:0] lo_s;
         logic [HALF_W:0] hi_s;
         assign lo_s = {1'b0, xa[HALF_W-1:0]} + {1'b0, yb[HALF_W-1:0]}
                     + {{HALF_W{1'b0}}, cin};
         assign hi_s = {1'b0, xa[WORD_W-1:HALF_W]} + {1'b0, yb[WORD_W-1:HALF_W]}
                     + {{HALF_W{1'b0}}, lo_s[HALF_W]};
         assign sum  = {hi_s, lo_s[HALF_W-1:0]};
      end else begin : g_flat
         assign sum = {1'b0, xa} + {1'b0, yb} + {{WORD_W{1'b0}}, cin};
      end
   endgenerate

   logic c_into_msb;
   assign c_into_msb = xa[WORD_W-1] ^ yb[WORD_W-1] ^ sum[WORD_W-1];

   assign res   = sum[WORD_W-1:0];
   assign flg.n = sum[WORD_W-1];
   assign flg.z = (sum[WORD_W-1:0] == '0);
   assign flg.c = sum[WORD_W];
   assign flg.v = sum[WORD_W] ^ c_into_msb;
   assign flg.h = xa[WORD_W-4] ^ yb[WORD_W-4] ^ sum[WORD_W-4];

   always_comb begin
      flg_we  = '0;
      pair_we = 1'b0;
      mem_we  = 1'b0;
      unique case (op)
         PW_ADDW, PW_SUBW: begin
            flg_we  = 5'b11111;
            pair_we = 1'b1;
         end
         PW_CMPW: flg_we = 5'b10011;
         PW_INCW, PW_DECW: begin
            flg_we = 5'b10010;
            mem_we = 1'b1;
         end
         PW_LDW: begin
            flg_we  = 5'b10010;
            pair_we = 1'b1;
         end
         default: begin
            flg_we = '0;
         end
      endcase
   end

endmodule

// File: rtl/pw_seq.sv
module pw_seq
   import pw_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic accept,
   output logic busy,
   output logic ph_lo,
   output logic ph_hi,
   output logic fin
);
   pw_seq_e state_q;
   pw_seq_e state_d;

   assign accept = (state_q == SQ_IDLE) && start;
   assign busy   = (state_q != SQ_IDLE);
   assign ph_lo  = (state_q == SQ_LO);
   assign ph_hi  = (state_q == SQ_HI);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         SQ_IDLE: if (start) state_d = SQ_LO;
         SQ_LO:   state_d = SQ_HI;
         SQ_HI:   state_d = SQ_IDLE;
         default: state_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         fin     <= 1'b0;
      end else begin
         state_q <= state_d;
         fin     <= (state_q == SQ_HI);
      end
   end

endmodule

// File: rtl/pw_addr.sv
module pw_addr #(
   parameter int ADDR_W = 16,
   parameter int PAGE_W = 8
) (
   input  logic [ADDR_W-PAGE_W-1:0] base,
   input  logic [PAGE_W-1:0]        off,
   input  logic                     hi_sel,
   output logic [ADDR_W-1:0]        addr
);
   logic [PAGE_W-1:0] off_next;

   // carry out of the offset is dropped: the page never changes
   assign off_next = off + {{(PAGE_W-1){1'b0}}, 1'b1};
   assign addr     = {base, (hi_sel ? off_next : off)};

endmodule

// File: rtl/word_pair_alu.sv
module word_pair_alu
   import pw_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int PAGE_W    = 8,
   parameter bit SPLIT_ADD = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic [2:0]               op,
   input  logic [ADDR_W-PAGE_W-1:0] page,
   input  logic [PAGE_W-1:0]        offset,
   input  logic [15:0]              pair_in,
   output logic                     busy,
   output logic [ADDR_W-1:0]        mem_addr,
   output logic                     mem_rd,
   output logic                     mem_wr,
   output logic [7:0]               mem_wdata,
   input  logic [7:0]               mem_rdata,
   output logic                     done,
   output logic [15:0]              result,
   output logic [4:0]               flag_out,
   output logic [4:0]               flag_we,
   output logic                     pair_we
);
   localparam int BASE_W = ADDR_W - PAGE_W;
   localparam int WORD_W = 16;
   localparam int BYTE_W = WORD_W / 2;

   initial begin
      if (PAGE_W < 2 || PAGE_W >= ADDR_W)
         $fatal(1, "word_pair_alu: PAGE_W must be in 2..ADDR_W-1");
   end

   logic accept, ph_lo, ph_hi, fin;

   pw_seq u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .accept (accept),
      .busy   (busy),
      .ph_lo  (ph_lo),
      .ph_hi  (ph_hi),
      .fin    (fin)
   );

   // captured operation context
   logic [2:0]        op_q;
   logic [BASE_W-1:0] base_q;
   logic [PAGE_W-1:0] off_q;
   logic [WORD_W-1:0] pair_q;
   logic [BYTE_W-1:0] lo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q   <= '0;
         base_q <= '0;
         off_q  <= '0;
         pair_q <= '0;
         lo_q   <= '0;
      end else begin
         if (accept) begin
            op_q   <= op;
            base_q <= page;
            off_q  <= offset;
            pair_q <= pair_in;
         end
         if (ph_lo) lo_q <= mem_rdata;
      end
   end

   logic [ADDR_W-1:0] addr_w;

   pw_addr #(
      .ADDR_W (ADDR_W),
      .PAGE_W (PAGE_W)
   ) u_addr (
      .base   (base_q),
      .off    (off_q),
      .hi_sel (ph_hi),
      .addr   (addr_w)
   );

   // low phase sees only the low byte; its carry is resolved in the high phase
   logic [WORD_W-1:0]    mword;
   logic [WORD_W-1:0]    core_res;
   pw_flags_t            core_flg;
   logic [PW_FLAG_W-1:0] core_we;
   logic                 core_pwe;
   logic                 core_mwe;

   assign mword = ph_hi ? {mem_rdata, lo_q} : {{BYTE_W{1'b0}}, mem_rdata};

   pw_word_core #(
      .SPLIT_ADD (SPLIT_ADD),
      .WORD_W    (WORD_W)
   ) u_core (
      .op      (pw_op_e'(op_q)),
      .pair    (pair_q),
      .mword   (mword),
      .res     (core_res),
      .flg     (core_flg),
      .flg_we  (core_we),
      .pair_we (core_pwe),
      .mem_we  (core_mwe)
   );

   assign mem_rd    = ph_lo | ph_hi;
   assign mem_addr  = mem_rd ? addr_w : '0;
   assign mem_wr    = mem_rd & core_mwe;
   assign mem_wdata = ph_hi ? core_res[WORD_W-1:BYTE_W] : core_res[BYTE_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result   <= '0;
         flag_out <= '0;
         flag_we  <= '0;
         pair_we  <= 1'b0;
      end else begin
         flag_we <= ph_hi ? core_we : '0;
         pair_we <= ph_hi & core_pwe;
         if (ph_hi) begin
            result   <= core_res;
            flag_out <= core_flg;
         end
      end
   end

   assign done = fin;

endmodule

// File: rtl/word_pair_alu_chk.sv
module word_pair_alu_chk #(
   parameter int ADDR_W = 16,
   parameter int PAGE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_rd,
   input logic              mem_wr,
   input logic              done,
   input logic [15:0]       result,
   input logic [4:0]        flag_out,
   input logic [4:0]        flag_we,
   input logic              pair_we
);

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8
   lo_then_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_rd) |=> mem_rd);

   // R8
   done_follows_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_rd) |-> done);

   // R7
   hi_offset_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_rd) |=> (mem_addr[PAGE_W-1:0] == PAGE_W'($past(mem_addr[PAGE_W-1:0]) + 1'b1)));

   // R7
   same_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_rd) |=> (mem_addr[ADDR_W-1:PAGE_W] == $past(mem_addr[ADDR_W-1:PAGE_W])));

   // R6
   write_in_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> (mem_rd && busy));

   // R2
   vh_only_with_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_we[3] || flag_we[2]) |-> pair_we);

   // R4
   n_is_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && flag_we[4]) |-> (flag_out[4] == result[15]));

   // R4
   z_is_all_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && flag_we[1]) |-> (flag_out[1] == (result == 16'h0000)));

   // R8
   enables_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pair_we || (flag_we != 5'b00000)) |-> done);

endmodule

bind word_pair_alu word_pair_alu_chk #(
   .ADDR_W (ADDR_W),
   .PAGE_W (PAGE_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (busy),
   .mem_addr (mem_addr),
   .mem_rd   (mem_rd),
   .mem_wr   (mem_wr),
   .done     (done),
   .result   (result),
   .flag_out (flag_out),
   .flag_we  (flag_we),
   .pair_we  (pair_we)
);

// File: tb/word_pair_alu_bench.sv
module word_pair_alu_bench;
   localparam int AW = 10;
   localparam int PW = 8;
   localparam int BW = AW - PW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [2:0]    op = '0;
   logic [BW-1:0] page = '0;
   logic [PW-1:0] offset = '0;
   logic [15:0]   pair_in = '0;
   logic          busy;
   logic [AW-1:0] mem_addr;
   logic          mem_rd, mem_wr;
   logic [7:0]    mem_wdata, mem_rdata;
   logic          done;
   logic [15:0]   result;
   logic [4:0]    flag_out, flag_we;
   logic          pair_we;

   always #5 clk = ~clk;

   word_pair_alu #(.ADDR_W(AW), .PAGE_W(PW), .SPLIT_ADD(1'b1)) u_word_pair_alu (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .page(page),
      .offset(offset), .pair_in(pair_in), .busy(busy), .mem_addr(mem_addr),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .done(done), .result(result),
      .flag_out(flag_out), .flag_we(flag_we), .pair_we(pair_we)
   );

   // memory model and access log
   logic [7:0]    mem_q [0:(1<<AW)-1];
   int            cyc = 0;
   int            rd_n = 0, wr_n = 0;
   logic [AW-1:0] rd_a0, rd_a1, wr_a0, wr_a1;
   int            rd_c0, rd_c1, wr_c0, wr_c1;

   assign mem_rdata = mem_q[mem_addr];

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (mem_wr) mem_q[mem_addr] <= mem_wdata;
      if (mem_rd) begin
         if (rd_n == 0) begin rd_a0 <= mem_addr; rd_c0 <= cyc; end
         if (rd_n == 1) begin rd_a1 <= mem_addr; rd_c1 <= cyc; end
         rd_n <= rd_n + 1;
      end
      if (mem_wr) begin
         if (wr_n == 0) begin wr_a0 <= mem_addr; wr_c0 <= cyc; end
         if (wr_n == 1) begin wr_a1 <= mem_addr; wr_c1 <= cyc; end
         wr_n <= wr_n + 1;
      end
   end

   int total = 0;
   int bad   = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      summary();
   end

   // reference model derived from the requirements
   task automatic model(input int opc, input logic [15:0] p, input logic [15:0] m,
                        output logic [15:0] r, output logic [4:0] f,
                        output logic [4:0] we, output bit pwe, output bit mwe);
      logic [16:0] s;
      logic [7:0]  ohi;
      logic        v, h, c;
      s = '0; ohi = '0; v = 0; h = 0; c = 0;
      we = 5'b00000; pwe = 0; mwe = 0; r = '0;
      case (opc)
         0: begin
            s = {1'b0, p} + {1'b0, m}; ohi = m[15:8];
            r = s[15:0]; c = s[16];
            v = (p[15] == m[15]) && (r[15] != p[15]);
            we = 5'b11111; pwe = 1;
         end
         1: begin
            s = {1'b0, p} + {1'b0, ~m} + 17'd1; ohi = ~m[15:8];
            r = s[15:0]; c = (p >= m);
            v = (p[15] != m[15]) && (r[15] != p[15]);
            we = 5'b11111; pwe = 1;
         end
         2: begin
            r = p - m; c = (p >= m); we = 5'b10011;
         end
         3: begin r = m + 16'd1; we = 5'b10010; mwe = 1; end
         4: begin r = m - 16'd1; we = 5'b10010; mwe = 1; end
         5: begin r = m; we = 5'b10010; pwe = 1; end
         default: begin we = 5'b00000; end
      endcase
      h = ((p[15:8] ^ ohi ^ r[15:8]) >> 4) & 8'd1;
      f = {r[15], v, h, (r == 16'h0000), c};
   endtask

   // one operation with full timing, result and memory checks
   task automatic run_op(input int opc, input logic [15:0] p, input logic [15:0] m,
                         input logic [BW-1:0] pg, input logic [PW-1:0] off);
      logic [AW-1:0] a_lo, a_hi;
      logic [15:0]   er, mem_after;
      logic [4:0]    ef, ewe;
      bit            epwe, emwe;
      int            sc;
      a_lo = {pg, off};
      a_hi = {pg, PW'(off + 1'b1)};
      @(negedge clk);
      mem_q[a_lo] = m[7:0];
      mem_q[a_hi] = m[15:8];
      op = 3'(opc); pair_in = p; page = pg; offset = off; start = 1'b1;
      rd_n = 0; wr_n = 0;
      sc = cyc;
      model(opc, p, m, er, ef, ewe, epwe, emwe);
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      chk(done == 1'b0, "R8 no early done", done, 0);
      @(negedge clk);
      chk(done == 1'b1, "R8 done after high access", done, 1);
      chk(rd_n == 2, "R8 two accesses", rd_n, 2);
      chk(rd_c0 == sc + 1 && rd_c1 == sc + 2, "R8 access cycles", rd_c0, sc + 1);
      chk(rd_a0 == a_lo, "R7 low address", rd_a0, a_lo);
      chk(rd_a1 == a_hi, "R7 high address wraps in page", rd_a1, a_hi);
      chk(flag_we == ewe, "R4 flag enables", flag_we, ewe);
      chk(pair_we == epwe, "R1 pair enable", pair_we, epwe);
      if (opc < 6) begin
         chk(result == er, $sformatf("R2 R3 R5 R6 result op%0d", opc), result, er);
         chk((flag_out & ewe) == (ef & ewe), $sformatf("R4 flags op%0d", opc),
             flag_out & ewe, ef & ewe);
      end
      mem_after = {mem_q[a_hi], mem_q[a_lo]};
      if (emwe) begin
         chk(mem_after == er, "R6 memory word updated", mem_after, er);
         chk(wr_n == 2 && wr_a0 == a_lo && wr_a1 == a_hi && wr_c1 == wr_c0 + 1,
             "R6 low byte written first", wr_a0, a_lo);
      end else begin
         chk(wr_n == 0, "R10 R5 no memory write", wr_n, 0);
         chk(mem_after == m, "R10 memory unchanged", mem_after, m);
      end
      @(negedge clk);
      chk(done == 1'b0, "R8 done one cycle", done, 0);
      if (opc < 6)
         chk(result == er, "R8 result held", result, er);
   endtask

   logic [15:0] corners [12];
   initial begin
      corners = '{16'h0000, 16'h0001, 16'h007F, 16'h0080, 16'h00FF, 16'h0100,
                  16'h0FFF, 16'h1000, 16'h7FFF, 16'h8000, 16'h8001, 16'hFFFF};
   end

   initial begin
      logic [15:0] lf;
      logic [15:0] er;
      logic [4:0]  ef, ewe;
      bit          epwe, emwe;
      int          k;
      for (int i = 0; i < (1 << AW); i++) mem_q[i] = 8'h00;
      repeat (3) @(negedge clk);
      // R11 reset state
      chk({busy, done, mem_rd, mem_wr, pair_we} == 5'b0, "R11 reset controls",
          {busy, done, mem_rd, mem_wr, pair_we}, 0);
      chk(flag_we == 5'b0 && result == 16'h0, "R11 reset outputs", result, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 1'b0 && done == 1'b0 && result == 16'h0, "R11 after release",
          {busy, done}, 0);

      // near-exhaustive corner sweep over every operation code
      k = 0;
      for (int o = 0; o < 8; o++)
         for (int a = 0; a < 12; a++)
            for (int b = 0; b < 12; b++) begin
               run_op(o, corners[a], corners[b], BW'(k), PW'(k * 37));
               k++;
            end

      // page-end offset for every operation (R7)
      for (int o = 0; o < 8; o++)
         run_op(o, 16'h1234, 16'h80FF, BW'(o), 8'hFF);

      // pseudo-random operands
      lf = 16'hACE1;
      for (int i = 0; i < 300; i++) begin
         logic [15:0] p2;
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         p2 = lf;
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         run_op(i % 6, p2, lf, BW'(i), PW'(lf[7:0] ^ p2[15:8]));
      end

      // R9 start during busy is ignored
      @(negedge clk);
      mem_q[10'h010] = 8'h34; mem_q[10'h011] = 8'h12;
      mem_q[10'h120] = 8'h99; mem_q[10'h121] = 8'h77;
      rd_n = 0; wr_n = 0;
      op = 3'd0; pair_in = 16'h0101; page = 2'd0; offset = 8'h10; start = 1'b1;
      @(negedge clk);
      op = 3'd5; page = 2'd1; offset = 8'h20; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      model(0, 16'h0101, 16'h1234, er, ef, ewe, epwe, emwe);
      chk(done == 1'b1 && result == er, "R9 first operation result", result, er);
      @(negedge clk);
      @(negedge clk);
      @(negedge clk);
      chk(done == 1'b0 && rd_n == 2, "R9 no second operation", rd_n, 2);

      summary();
   end

endmodule